// File: doc/BRIEF.md
# Interrupt Acknowledge and Cascade Sequencer

This block answers the two-pulse interrupt acknowledge handshake of a processor and coordinates a tree of interrupt controllers: one master and up to eight slaves behind it, for at most 64 request levels. An upstream priority resolver supplies the granted level. The sequencer turns the two acknowledge strobes into at most one vector byte, placed on the data output for a single cycle. The vector byte joins the upper bits of a programmed base with the granted level.

In master role, the first strobe captures the granted level. If that level has a slave attached, the block then puts the level on the cascade lines as the slave's identity and leaves the data bus to the slave. In slave role, the block never drives the cascade lines. At the second strobe it compares the cascade input with its own programmed identity and answers only on a match. In unbuffered mode a select pin picks the role. In buffered mode the role comes from a configuration bit, and an enable output steers the external data transceivers instead.

Top module: `iack_cascade_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `data_oe`, `cas_oe` and `buf_en` are 0, and `data_out` and `cas_out` are 0.
- R2: In master role, when the level captured at the first strobe has its bit set in `slave_map`, `cas_out` equals that level and `cas_oe` is 1 from the cycle after the first strobe through the vector cycle. Both return to 0 in the cycle after the vector cycle.
- R3: When the block supplies the vector, `data_oe` is 1 for exactly the one cycle after the second strobe, and `data_out` = {`vec_base`[7:3], captured level}. `data_out` is 0 whenever `data_oe` is 0.
- R4: In master role, when the captured level has a slave attached, `data_oe` stays 0 after the second strobe. When the level has no slave, `cas_oe` stays 0 and the master supplies the vector itself.
- R5: In slave role, `cas_oe` stays 0. At the second strobe the vector is supplied if `cas_in` equals `own_id`; otherwise `data_oe` stays 0.
- R6: The level and the role are captured at the first strobe. Changes to `grant_level`, `sel_pin_in` or `cfg_master` before the second strobe alter neither `cas_out` nor the vector.
- R7: Role is master when `sel_pin_in`=1 and slave when it is 0 in unbuffered mode (`buffered`=0). In buffered mode the role follows `cfg_master` (1 = master), and `sel_pin_in` is ignored.
- R8: `buf_en` is 1 exactly in the cycles where `data_oe` is 1 while `buffered`=1. With `buffered`=0 it stays 0.
- R9: No vector is output without two strobes. A strobe that arrives in the vector cycle is ignored, and the next strobe after it starts a new sequence as a first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_stb | input | 1 | One-cycle strobe per acknowledge pulse |
| grant_level | input | 3 | Level granted by the priority resolver |
| slave_map | input | 8 | Bit n set: a slave hangs on level n (master role) |
| vec_base | input | 8 | Programmed vector base; bits 7:3 are used |
| own_id | input | 3 | Identity of this block in slave role |
| buffered | input | 1 | 1 = buffered mode |
| cfg_master | input | 1 | Role in buffered mode, 1 = master |
| sel_pin_in | input | 1 | Role select pin in unbuffered mode, 1 = master |
| cas_in | input | 3 | Cascade lines as received |
| cas_out | output | 3 | Cascade code driven in master role |
| cas_oe | output | 1 | Drive enable for the cascade lines |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | Drive enable for the data bus |
| buf_en | output | 1 | External data buffer enable in buffered mode |

## Verification
The bench sweeps every level against a mixed slave map in master role. A design that ignored the map would put a vector on the bus while a slave also answers. A design that drove the wrong cascade code would wake the wrong slave. In slave role it tries all 64 pairings of identity and cascade code; a faulty comparator either stays silent or answers for another slave. Between the two strobes the bench changes the granted level and the role inputs, so a design that does not capture them builds a vector for the wrong level. It also sends a strobe into the vector cycle; a design that counts that strobe would emit a vector on the very next strobe. Buffered runs with the select pin set against the role bit catch a design that reads the pin in that mode.

// File: rtl/iack_pkg.sv
package iack_pkg;

    localparam int DEF_LVL_W = 3;
    localparam int DEF_VEC_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT2 = 2'd1,
        PH_DRIVE = 2'd2
    } iack_phase_e;

    function automatic logic pick_master(input logic buffered,
                                         input logic cfg_master,
                                         input logic sel_pin);
        return buffered ? cfg_master : sel_pin;
    endfunction

endpackage

// File: rtl/iack_phase_ctrl.sv
module iack_phase_ctrl
    import iack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ack_stb,
    output iack_phase_e phase,
    output logic        first_hit,
    output logic        second_hit
);

    iack_phase_e phase_q;

    always_comb begin
        first_hit  = ack_stb && (phase_q == PH_IDLE);
        second_hit = ack_stb && (phase_q == PH_WAIT2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:  if (first_hit)  phase_q <= PH_WAIT2;
                PH_WAIT2: if (second_hit) phase_q <= PH_DRIVE;
                PH_DRIVE: phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;

    AST_DRIVE_LASTS_ONE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DRIVE) |=> (phase_q == PH_IDLE)); // R9

    AST_DRIVE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_q == PH_DRIVE) |-> $past(ack_stb)); // R9

endmodule

// File: rtl/iack_cascade_port.sv
module iack_cascade_port
    import iack_pkg::*;
#(
    parameter int LVL_W   = DEF_LVL_W,
    localparam int NUM_LVL = 1 << LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               first_hit,
    input  iack_phase_e        phase,
    input  logic               role_master,
    input  logic [LVL_W-1:0]   grant_level,
    input  logic [NUM_LVL-1:0] slave_map,
    output logic [LVL_W-1:0]   lat_level,
    output logic               lat_master,
    output logic               lat_cascaded,
    output logic [LVL_W-1:0]   cas_out,
    output logic               cas_oe
);

    logic has_slave;

    always_comb begin
        has_slave = slave_map[grant_level];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_level    <= '0;
            lat_master   <= 1'b0;
            lat_cascaded <= 1'b0;
            cas_out      <= '0;
            cas_oe       <= 1'b0;
        end else if (first_hit) begin
            lat_level    <= grant_level;
            lat_master   <= role_master;
            lat_cascaded <= role_master && has_slave;
            if (role_master && has_slave) begin
                cas_out <= grant_level;
                cas_oe  <= 1'b1;
            end
        end else if (phase == PH_DRIVE) begin
            cas_out <= '0;
            cas_oe  <= 1'b0;
        end
    end

    AST_CAS_HELD: assert property (@(posedge clk) disable iff (rst)
        (cas_oe && $past(cas_oe)) |-> $stable(cas_out)); // R6

    AST_CAS_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cas_oe |-> (cas_out == '0)); // R2

endmodule

// File: rtl/iack_vector_out.sv
module iack_vector_out
    import iack_pkg::*;
#(
    parameter int LVL_W = DEF_LVL_W,
    parameter int VEC_W = DEF_VEC_W,
    localparam int BASE_W = VEC_W - LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             second_hit,
    input  logic             lat_master,
    input  logic             lat_cascaded,
    input  logic [LVL_W-1:0] lat_level,
    input  logic [LVL_W-1:0] cas_in,
    input  logic [LVL_W-1:0] own_id,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             buffered,
    output logic [VEC_W-1:0] data_out,
    output logic             data_oe,
    output logic             buf_en
);

    logic supply;
    logic [BASE_W-1:0] base_hi;

    always_comb begin
        base_hi = vec_base[VEC_W-1:LVL_W];
        if (lat_master) supply = !lat_cascaded;
        else            supply = (cas_in == own_id);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            data_oe  <= 1'b0;
            buf_en   <= 1'b0;
        end else if (second_hit && supply) begin
            data_out <= {base_hi, lat_level};
            data_oe  <= 1'b1;
            buf_en   <= buffered;
        end else begin
            data_out <= '0;
            data_oe  <= 1'b0;
            buf_en   <= 1'b0;
        end
    end

    AST_DATA_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        data_oe |=> !data_oe); // R3

    AST_BUF_EN_TRACK: assert property (@(posedge clk) disable iff (rst)
        buf_en |-> data_oe); // R8

    AST_DATA_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> (data_out == '0)); // R3

endmodule

// File: rtl/iack_cascade_seq.sv
module iack_cascade_seq
    import iack_pkg::*;
#(
    parameter int LVL_W = DEF_LVL_W,
    parameter int VEC_W = DEF_VEC_W,
    localparam int NUM_LVL = 1 << LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_stb,
    input  logic [LVL_W-1:0]   grant_level,
    input  logic [NUM_LVL-1:0] slave_map,
    input  logic [VEC_W-1:0]   vec_base,
    input  logic [LVL_W-1:0]   own_id,
    input  logic               buffered,
    input  logic               cfg_master,
    input  logic               sel_pin_in,
    input  logic [LVL_W-1:0]   cas_in,
    output logic [LVL_W-1:0]   cas_out,
    output logic               cas_oe,
    output logic [VEC_W-1:0]   data_out,
    output logic               data_oe,
    output logic               buf_en
);

    iack_phase_e      phase;
    logic             first_hit;
    logic             second_hit;
    logic             role_master;
    logic [LVL_W-1:0] lat_level;
    logic             lat_master;
    logic             lat_cascaded;

    always_comb begin
        role_master = pick_master(buffered, cfg_master, sel_pin_in);
    end

    iack_phase_ctrl u_phase (
        .clk        (clk),
        .rst        (rst),
        .ack_stb    (ack_stb),
        .phase      (phase),
        .first_hit  (first_hit),
        .second_hit (second_hit)
    );

    iack_cascade_port #(.LVL_W(LVL_W)) u_cas (
        .clk          (clk),
        .rst          (rst),
        .first_hit    (first_hit),
        .phase        (phase),
        .role_master  (role_master),
        .grant_level  (grant_level),
        .slave_map    (slave_map),
        .lat_level    (lat_level),
        .lat_master   (lat_master),
        .lat_cascaded (lat_cascaded),
        .cas_out      (cas_out),
        .cas_oe       (cas_oe)
    );

    iack_vector_out #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_vec (
        .clk          (clk),
        .rst          (rst),
        .second_hit   (second_hit),
        .lat_master   (lat_master),
        .lat_cascaded (lat_cascaded),
        .lat_level    (lat_level),
        .cas_in       (cas_in),
        .own_id       (own_id),
        .vec_base     (vec_base),
        .buffered     (buffered),
        .data_out     (data_out),
        .data_oe      (data_oe),
        .buf_en       (buf_en)
    );

    AST_NO_CAS_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        !(cas_oe && data_oe)); // R4

    AST_DATA_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> $past(ack_stb)); // R9

    AST_SLAVE_NO_CAS: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_oe) |-> $past(role_master)); // R5

endmodule

// File: tb/iack_cascade_seq_bench.sv
module iack_cascade_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ack_stb = 1'b0;
    logic [2:0] grant_level = 3'd0;
    logic [7:0] slave_map = 8'b1010_0101;
    logic [7:0] vec_base = 8'hAD;
    logic [2:0] own_id = 3'd0;
    logic       buffered = 1'b0;
    logic       cfg_master = 1'b0;
    logic       sel_pin_in = 1'b1;
    logic [2:0] cas_in = 3'd0;
    logic [2:0] cas_out;
    logic       cas_oe;
    logic [7:0] data_out;
    logic       data_oe;
    logic       buf_en;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iack_cascade_seq u_iack_cascade_seq (
        .clk(clk), .rst(rst), .ack_stb(ack_stb), .grant_level(grant_level),
        .slave_map(slave_map), .vec_base(vec_base), .own_id(own_id),
        .buffered(buffered), .cfg_master(cfg_master), .sel_pin_in(sel_pin_in),
        .cas_in(cas_in), .cas_out(cas_out), .cas_oe(cas_oe),
        .data_out(data_out), .data_oe(data_oe), .buf_en(buf_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) ack_stb = 1'b1;
        @(negedge clk) ack_stb = 1'b0;
    endtask

    function automatic int vec_of(input int lvl);
        return (int'(vec_base) & 8'hF8) | lvl;
    endfunction

    // Master-role sequence; roles flipped between strobes to test capture.
    task automatic seq_master(input int lvl);
        bit cas = slave_map[lvl];
        grant_level = 3'(lvl);
        pulse();
        chk("R2 cas_oe after first strobe", int'(cas_oe), int'(cas));
        chk("R2 cas_out after first strobe", int'(cas_out), cas ? lvl : 0);
        chk("R9 no data after one strobe", int'(data_oe), 0);
        grant_level = ~3'(lvl);
        sel_pin_in = ~sel_pin_in;
        cfg_master = ~cfg_master;
        pulse();
        chk("R4 data_oe master", int'(data_oe), int'(!cas));
        chk("R3 R6 vector master", int'(data_out), cas ? 0 : vec_of(lvl));
        chk("R2 cas held in vector cycle", int'(cas_oe), int'(cas));
        chk("R8 buf_en master", int'(buf_en), int'(buffered && !cas));
        sel_pin_in = ~sel_pin_in;
        cfg_master = ~cfg_master;
        @(negedge clk);
        chk("R3 data drops", int'(data_oe), 0);
        chk("R2 cas released", int'(cas_oe), 0);
    endtask

    task automatic seq_slave(input int id, input int code, input int lvl);
        own_id = 3'(id);
        grant_level = 3'(lvl);
        pulse();
        chk("R5 slave never drives cas", int'(cas_oe), 0);
        cas_in = 3'(code);
        grant_level = 3'(lvl + 3);
        pulse();
        chk("R5 slave match", int'(data_oe), int'(id == code));
        chk("R5 R6 slave vector", int'(data_out), (id == code) ? vec_of(lvl) : 0);
        chk("R8 buf_en slave", int'(buf_en), int'(buffered && id == code));
        chk("R5 slave cas idle", int'(cas_oe), 0);
        @(negedge clk);
        chk("R3 slave data drops", int'(data_oe), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 data_oe in reset", int'(data_oe), 0);
        chk("R1 cas_oe in reset", int'(cas_oe), 0);
        chk("R1 buf_en in reset", int'(buf_en), 0);
        chk("R1 data_out in reset", int'(data_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cas_out after reset", int'(cas_out), 0);

        // R7 unbuffered master via select pin
        buffered = 1'b0; sel_pin_in = 1'b1; cfg_master = 1'b0;
        for (int l = 0; l < 8; l++) seq_master(l);
        vec_base = 8'h47;
        slave_map = 8'b0101_1010;
        for (int l = 0; l < 8; l++) seq_master(l);

        // R7 buffered master via config bit, pin says slave
        buffered = 1'b1; cfg_master = 1'b1; sel_pin_in = 1'b0;
        for (int l = 0; l < 8; l++) seq_master(l);

        // R7 unbuffered slave via pin
        buffered = 1'b0; sel_pin_in = 1'b0;
        for (int id = 0; id < 8; id++)
            for (int c = 0; c < 8; c++) seq_slave(id, c, (id + c) % 8);

        // R7 buffered slave, pin says master
        buffered = 1'b1; cfg_master = 1'b0; sel_pin_in = 1'b1;
        for (int id = 0; id < 8; id += 3) seq_slave(id, id, 7 - id);
        seq_slave(2, 5, 1);

        // R9: strobe during vector cycle is ignored
        buffered = 1'b0; sel_pin_in = 1'b1; slave_map = 8'h00;
        grant_level = 3'd4;
        @(negedge clk) ack_stb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 vector after two strobes", int'(data_oe), 1);
        @(negedge clk) ack_stb = 1'b0;
        chk("R9 ignored strobe gives no data", int'(data_oe), 0);
        pulse();
        chk("R9 fresh first strobe no data", int'(data_oe), 0);
        repeat (5) @(negedge clk);
        chk("R9 still no data without second", int'(data_oe), 0);
        pulse();
        chk("R9 second strobe completes", int'(data_out), vec_of(4));
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule